// File: doc/BRIEF.md
# Paced Parallel Input Capture Controller

This block captures a parallel digital input word under control of a set of mode inputs. Once software issues a start command with the input path enabled, the block either begins sampling immediately or first waits in an armed state for an edge of an external trigger line. The active trigger edge, rising or falling, is chosen by a polarity mode bit. Sampling is then paced by one of three sources. The timer source samples on each falling edge of an internal timer output. The request source samples on each rising edge of an external request strobe. With neither source selected, the block takes exactly one sample per start command.

Each sample goes to one of two places. In FIFO mode it goes to the write port of an external input FIFO. A sample that meets a full FIFO is dropped and raises a sticky overrun flag. Otherwise the sample goes to a holding register that the CPU consumes with a read strobe. When acknowledge mode is on, a one-cycle acknowledge pulse follows each FIFO write and each CPU read of a held sample. The request, trigger and timer lines are asynchronous. Each passes through a synchronizer chain before its edges are detected. Dropping the input-enable line stops all activity at once.

Top module: `dcap_top`

## Requirements
- R1: After reset, `fifo_wr`, `ack_out`, `overrun` and `hold_valid` are 0 and `hold_data` is all zeros.
- R2: With `mode_req_en`=1 and `mode_tmr_en`=0, while running, each rising edge of `req_in` captures `data_in` once. With `mode_req_en`=0, edges on `req_in` produce no sample.
- R3: With `mode_tmr_en`=1, while running, each falling edge of `tmr_in` captures one sample and its rising edges capture nothing. This holds whatever the value of `mode_req_en`, so timer pacing wins over request pacing.
- R4: With both pacing bits 0, each start command with the input enabled produces exactly one sample, after which the block returns to idle.
- R5: With `mode_fifo_en`=1 a sample is presented as a one-cycle `fifo_wr` pulse with the word on `fifo_wdata`, and the holding register is left unchanged. With `mode_fifo_en`=0 the sample is stored in `hold_data` and `hold_valid` is set. A `cpu_rd` pulse clears `hold_valid`.
- R6: With `mode_trg_en`=1, a start command arms the block, and no sample is taken until an active edge of `trg_in` has been seen. `mode_trg_rise`=1 selects the rising edge and 0 selects the falling edge. The opposite edge does not end the wait.
- R7: With `mode_ack_en`=1, `ack_out` pulses in the cycle after each `fifo_wr` pulse and in the cycle after a `cpu_rd` that consumes a valid held sample. With `mode_ack_en`=0, `ack_out` stays 0.
- R8: `in_enable`=0 returns the block to idle at the next clock. This cancels any trigger wait or pacing, and no further sample is taken until a new start command arrives.
- R9: A FIFO-mode sample taken while `fifo_full`=1 is dropped, with no `fifo_wr` pulse, and sets `overrun`. `overrun` stays set until `clr_status` is pulsed.
- R10: `ack_out` is never high for two consecutive cycles.
- R11: `req_in`, `trg_in` and `tmr_in` each pass through `SYNC_STAGES` flip-flops before edge detection. Holding a line at one level for a long time yields only one edge, and so at most one sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_in | input | DATA_W | Parallel input word |
| req_in | input | 1 | Asynchronous request strobe |
| trg_in | input | 1 | Asynchronous external trigger |
| tmr_in | input | 1 | Asynchronous timer output |
| mode_req_en | input | 1 | Pace by request rising edges |
| mode_tmr_en | input | 1 | Pace by timer falling edges (priority) |
| mode_fifo_en | input | 1 | Route samples to the FIFO port |
| mode_trg_en | input | 1 | Wait for a trigger edge after start |
| mode_trg_rise | input | 1 | Trigger polarity: 1 rising, 0 falling |
| mode_ack_en | input | 1 | Enable acknowledge pulses |
| in_enable | input | 1 | Input path enable; 0 stops everything |
| start | input | 1 | Start command pulse |
| cpu_rd | input | 1 | CPU read strobe for the holding register |
| clr_status | input | 1 | Clears the overrun flag |
| fifo_full | input | 1 | Input FIFO full |
| fifo_wr | output | 1 | FIFO write pulse |
| fifo_wdata | output | DATA_W | FIFO write data |
| hold_data | output | DATA_W | Holding register |
| hold_valid | output | 1 | Holding register contains an unread sample |
| ack_out | output | 1 | Acknowledge pulse |
| overrun | output | 1 | Sticky FIFO overrun flag |

## Verification
The bench builds the block with DATA_W=12 and SYNC_STAGES=3. The odd word width exposes slicing mistakes in the data path. The deeper synchronizer lengthens the path from a pin to a sample by one cycle, which exercises the parameterized chain rather than its two-stage default. With these values, a strobe phase of six cycles is always long enough for an edge to reach the sampling logic before the bench looks at the outputs. That lets random data words, request edges, timer edges and trigger edges be checked one after another in both the FIFO and holding modes.

// File: rtl/dcap_pkg.sv
package dcap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } run_state_e;

    typedef enum logic [1:0] {
        PACE_ONCE = 2'd0,
        PACE_REQ  = 2'd1,
        PACE_TMR  = 2'd2
    } pace_e;

endpackage

// File: rtl/dcap_edge_sync.sv
module dcap_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    input  logic edge_sel,
    output logic edge_hit
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_d, chain_q;
    logic             sync_lvl, prev_lvl;

    generate
        if (STAGES < 1) begin : g_bad
            initial $error("dcap_edge_sync: STAGES must be at least 1");
        end
    endgenerate

    always_comb begin
        chain_d = {chain_q[CHAIN-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_lvl = chain_q[STAGES-1];
    assign prev_lvl = chain_q[STAGES];
    assign edge_hit = edge_sel ? (sync_lvl & ~prev_lvl) : (~sync_lvl & prev_lvl);

    // R11: each detected edge is a single-cycle pulse
    assert_edge_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit && $stable(edge_sel)) |=> !edge_hit || !$stable(edge_sel));

endmodule

// File: rtl/dcap_seq.sv
module dcap_seq
    import dcap_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  enable,
    input  logic  start,
    input  logic  trg_en,
    input  logic  trg_hit,
    input  pace_e pace,
    input  logic  pace_hit,
    output logic  sample,
    output logic  running
);
    typedef struct packed {
        run_state_e st;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d  = seq_q;
        sample = 1'b0;
        if (!enable) begin
            seq_d.st = ST_IDLE;
        end else begin
            case (seq_q.st)
                ST_IDLE: begin
                    if (start) seq_d.st = trg_en ? ST_ARM : ST_RUN;
                end
                ST_ARM: begin
                    if (trg_hit) seq_d.st = ST_RUN;
                end
                ST_RUN: begin
                    if (pace == PACE_ONCE) begin
                        sample   = 1'b1;
                        seq_d.st = ST_IDLE;
                    end else if (pace_hit) begin
                        sample = 1'b1;
                    end
                end
                default: seq_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE};
        else        seq_q <= seq_d;
    end

    assign running = (seq_q.st == ST_RUN);

    // R8: disable forces idle on the next clock
    assert_disable_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (seq_q.st == ST_IDLE));

    // R6: armed state persists until a trigger edge
    assert_arm_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_ARM && enable && !trg_hit) |=> (seq_q.st == ST_ARM));

    // R4: a one-shot run returns to idle after its sample
    assert_once_returns_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_RUN && pace == PACE_ONCE) |=> (seq_q.st == ST_IDLE));

endmodule

// File: rtl/dcap_path.sv
module dcap_path #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [DATA_W-1:0] data_in,
    input  logic              fifo_en,
    input  logic              fifo_full,
    input  logic              ack_en,
    input  logic              cpu_rd,
    input  logic              clr_status,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_valid,
    output logic              ack_out,
    output logic              overrun
);
    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic              hvalid;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic              ack;
        logic              ovr;
    } path_t;

    path_t path_d, path_q;
    logic  to_fifo, to_hold, rd_hit, ack_evt;

    always_comb begin
        path_d    = path_q;
        to_fifo   = sample & fifo_en & ~fifo_full;
        to_hold   = sample & ~fifo_en;
        rd_hit    = cpu_rd & path_q.hvalid;
        ack_evt   = ack_en & (path_q.wr | rd_hit) & ~path_q.ack;

        path_d.wr  = to_fifo;
        path_d.ack = ack_evt;
        if (to_fifo) path_d.wdata = data_in;

        if (to_hold) begin
            path_d.hold   = data_in;
            path_d.hvalid = 1'b1;
        end else if (rd_hit) begin
            path_d.hvalid = 1'b0;
        end

        if (clr_status) path_d.ovr = 1'b0;
        if (sample && fifo_en && fifo_full) path_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) path_q <= '0;
        else        path_q <= path_d;
    end

    assign fifo_wr    = path_q.wr;
    assign fifo_wdata = path_q.wdata;
    assign hold_data  = path_q.hold;
    assign hold_valid = path_q.hvalid;
    assign ack_out    = path_q.ack;
    assign overrun    = path_q.ovr;

    // R9: no write is issued against a full FIFO
    assert_no_write_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && fifo_en && fifo_full) |=> !fifo_wr && overrun);

    // R9: overrun is sticky until cleared
    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr_status) |=> overrun);

    // R10: acknowledge is one cycle wide
    assert_ack_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_out |=> !ack_out);

    // R7: acknowledge only when enabled
    assert_ack_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_en |=> !ack_out);

    // R5: a read with no new sample empties the holding register
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && hold_valid && !(sample && !fifo_en)) |=> !hold_valid);

    // R5: FIFO-mode samples leave the holding register untouched
    assert_fifo_keeps_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && fifo_en) |=> $stable(hold_data));

endmodule

// File: rtl/dcap_top.sv
module dcap_top
    import dcap_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic              req_in,
    input  logic              trg_in,
    input  logic              tmr_in,
    input  logic              mode_req_en,
    input  logic              mode_tmr_en,
    input  logic              mode_fifo_en,
    input  logic              mode_trg_en,
    input  logic              mode_trg_rise,
    input  logic              mode_ack_en,
    input  logic              in_enable,
    input  logic              start,
    input  logic              cpu_rd,
    input  logic              clr_status,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_valid,
    output logic              ack_out,
    output logic              overrun
);
    logic  req_hit, trg_hit, tmr_hit;
    logic  pace_hit, sample, running;
    pace_e pace;

    dcap_edge_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .async_in(req_in),
        .edge_sel(1'b1), .edge_hit(req_hit)
    );

    dcap_edge_sync #(.STAGES(SYNC_STAGES)) u_trg_sync (
        .clk(clk), .rst_n(rst_n), .async_in(trg_in),
        .edge_sel(mode_trg_rise), .edge_hit(trg_hit)
    );

    dcap_edge_sync #(.STAGES(SYNC_STAGES)) u_tmr_sync (
        .clk(clk), .rst_n(rst_n), .async_in(tmr_in),
        .edge_sel(1'b0), .edge_hit(tmr_hit)
    );

    always_comb begin
        if (mode_tmr_en) begin
            pace     = PACE_TMR;
            pace_hit = tmr_hit;
        end else if (mode_req_en) begin
            pace     = PACE_REQ;
            pace_hit = req_hit;
        end else begin
            pace     = PACE_ONCE;
            pace_hit = 1'b0;
        end
    end

    dcap_seq u_seq (
        .clk(clk), .rst_n(rst_n), .enable(in_enable), .start(start),
        .trg_en(mode_trg_en), .trg_hit(trg_hit), .pace(pace),
        .pace_hit(pace_hit), .sample(sample), .running(running)
    );

    dcap_path #(.DATA_W(DATA_W)) u_path (
        .clk(clk), .rst_n(rst_n), .sample(sample), .data_in(data_in),
        .fifo_en(mode_fifo_en), .fifo_full(fifo_full), .ack_en(mode_ack_en),
        .cpu_rd(cpu_rd), .clr_status(clr_status), .fifo_wr(fifo_wr),
        .fifo_wdata(fifo_wdata), .hold_data(hold_data), .hold_valid(hold_valid),
        .ack_out(ack_out), .overrun(overrun)
    );

    // R3: timer pacing ignores request edges
    assert_tmr_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && mode_tmr_en && !tmr_hit) |-> !sample);

    // R2: request edges are ignored when request pacing is off
    assert_req_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !mode_req_en && !mode_tmr_en) |=> !running);

endmodule

// File: tb/dcap_top_test.sv
module dcap_top_test;
    localparam int DW = 12;
    localparam int SS = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic req_in = 0, trg_in = 0, tmr_in = 0;
    logic mode_req_en = 0, mode_tmr_en = 0, mode_fifo_en = 0;
    logic mode_trg_en = 0, mode_trg_rise = 0, mode_ack_en = 0;
    logic in_enable = 0, start = 0, cpu_rd = 0, clr_status = 0, fifo_full = 0;
    logic          fifo_wr, hold_valid, ack_out, overrun;
    logic [DW-1:0] fifo_wdata, hold_data;

    int checks = 0, fails = 0;
    int wr_cnt = 0, ack_cnt = 0, ack_wide = 0;
    logic [DW-1:0] last_w = '0;
    logic ack_prev = 1'b0;
    bit done = 0;

    always #2 clk = ~clk;

    dcap_top #(.DATA_W(DW), .SYNC_STAGES(SS)) uut (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .req_in(req_in),
        .trg_in(trg_in), .tmr_in(tmr_in), .mode_req_en(mode_req_en),
        .mode_tmr_en(mode_tmr_en), .mode_fifo_en(mode_fifo_en),
        .mode_trg_en(mode_trg_en), .mode_trg_rise(mode_trg_rise),
        .mode_ack_en(mode_ack_en), .in_enable(in_enable), .start(start),
        .cpu_rd(cpu_rd), .clr_status(clr_status), .fifo_full(fifo_full),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .hold_data(hold_data),
        .hold_valid(hold_valid), .ack_out(ack_out), .overrun(overrun)
    );

    always @(negedge clk) begin
        if (fifo_wr) begin
            wr_cnt++;
            last_w = fifo_wdata;
        end
        if (ack_out) ack_cnt++;
        if (ack_out && ack_prev) ack_wide++;
        ack_prev = ack_out;
    end

    function automatic int exp_acks(input bit ack_en);
        return ack_en ? 1 : 0;
    endfunction

    function automatic int exp_writes(input bit fifo_en, input bit full);
        return (fifo_en && !full) ? 1 : 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart();
        @(negedge clk); in_enable = 0;
        @(negedge clk); in_enable = 1; start = 1;
        @(negedge clk); start = 0;
        wait_n(2);
    endtask

    task automatic req_pulse(input logic [DW-1:0] d, input int hi);
        @(negedge clk); data_in = d; req_in = 1;
        wait_n(hi);
        req_in = 0;
        wait_n(6);
    endtask

    task automatic tmr_set(input logic v);
        @(negedge clk); tmr_in = v;
        wait_n(6);
    endtask

    task automatic trg_set(input logic v);
        @(negedge clk); trg_in = v;
        wait_n(6);
    endtask

    task automatic read_hold();
        @(negedge clk); cpu_rd = 1;
        @(negedge clk); cpu_rd = 0;
        wait_n(2);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        int w0, a0;
        logic [DW-1:0] d;
        bit f;
        void'($urandom(32'd1234));
        wait_n(4);
        rst_n = 1;
        wait_n(1);
        // R1 reset state
        chk(!fifo_wr && !ack_out && !overrun && !hold_valid && hold_data == '0,
            "R1", {fifo_wr, ack_out, overrun, hold_valid}, 0);

        // R4 one-shot into FIFO and into hold
        mode_fifo_en = 1; mode_ack_en = 1; data_in = 12'h5A3;
        w0 = wr_cnt; restart(); wait_n(3);
        chk(wr_cnt == w0 + 1 && last_w == 12'h5A3, "R4", wr_cnt - w0, 1);
        wait_n(6);
        chk(wr_cnt == w0 + 1, "R4", wr_cnt - w0, 1);
        mode_fifo_en = 0; data_in = 12'h0C7;
        restart(); wait_n(3);
        chk(hold_valid && hold_data == 12'h0C7, "R4", int'(hold_data), 12'h0C7);
        read_hold();

        // R2/R5/R7 random request-paced samples
        mode_req_en = 1; restart();
        for (int i = 0; i < 12; i++) begin
            d = DW'($urandom); f = 1'($urandom);
            mode_fifo_en = f;
            w0 = wr_cnt; a0 = ack_cnt;
            req_pulse(d, 6);
            if (f) begin
                chk(wr_cnt - w0 == exp_writes(f, 0) && last_w == d, "R2", int'(last_w), int'(d));
                chk(ack_cnt - a0 == exp_acks(1), "R7", ack_cnt - a0, 1);
            end else begin
                chk(hold_valid && hold_data == d && wr_cnt == w0, "R5", int'(hold_data), int'(d));
                read_hold();
                chk(!hold_valid, "R5", hold_valid, 0);
                chk(ack_cnt - a0 == exp_acks(1), "R7", ack_cnt - a0, 1);
            end
        end

        // R7 acknowledge disabled
        mode_fifo_en = 1; mode_ack_en = 0; a0 = ack_cnt; w0 = wr_cnt;
        req_pulse(12'h111, 6);
        chk(ack_cnt == a0 && wr_cnt == w0 + 1, "R7", ack_cnt - a0, exp_acks(0));
        mode_ack_en = 1;

        // R11 long high level gives one sample
        w0 = wr_cnt;
        req_pulse(12'h222, 40);
        chk(wr_cnt == w0 + 1, "R11", wr_cnt - w0, 1);

        // R3 timer priority, falling edge only
        mode_tmr_en = 1; w0 = wr_cnt;
        req_pulse(12'h333, 6);
        chk(wr_cnt == w0, "R3", wr_cnt - w0, 0);
        for (int i = 0; i < 4; i++) begin
            d = DW'($urandom); data_in = d; w0 = wr_cnt;
            tmr_set(1);
            chk(wr_cnt == w0, "R3", wr_cnt - w0, 0);
            tmr_set(0);
            chk(wr_cnt == w0 + 1 && last_w == d, "R3", int'(last_w), int'(d));
        end

        // R2 request edges ignored when request pacing is off (timer pacing idle)
        mode_req_en = 0; w0 = wr_cnt;
        req_pulse(12'h444, 6);
        chk(wr_cnt == w0, "R2", wr_cnt - w0, 0);
        mode_tmr_en = 0; mode_req_en = 1;

        // R9 overrun on full FIFO
        restart(); fifo_full = 1; w0 = wr_cnt;
        req_pulse(12'h555, 6);
        chk(wr_cnt == w0 && overrun, "R9", wr_cnt - w0, 0);
        fifo_full = 0;
        req_pulse(12'h556, 6);
        chk(overrun && wr_cnt == w0 + 1, "R9", overrun, 1);
        @(negedge clk); clr_status = 1;
        @(negedge clk); clr_status = 0;
        wait_n(1);
        chk(!overrun, "R9", overrun, 0);

        // R6 trigger, falling polarity
        mode_trg_en = 1; mode_trg_rise = 0; restart(); w0 = wr_cnt;
        req_pulse(12'h601, 6);
        chk(wr_cnt == w0, "R6", wr_cnt - w0, 0);
        trg_set(1);
        req_pulse(12'h602, 6);
        chk(wr_cnt == w0, "R6", wr_cnt - w0, 0);
        trg_set(0);
        req_pulse(12'h603, 6);
        chk(wr_cnt == w0 + 1 && last_w == 12'h603, "R6", int'(last_w), 12'h603);

        // R6 trigger, rising polarity
        mode_trg_rise = 1; restart(); w0 = wr_cnt;
        req_pulse(12'h611, 6);
        chk(wr_cnt == w0, "R6", wr_cnt - w0, 0);
        trg_set(1);
        req_pulse(12'h612, 6);
        chk(wr_cnt == w0 + 1 && last_w == 12'h612, "R6", int'(last_w), 12'h612);

        // R8 disable cancels trigger wait
        trg_set(0);
        restart();
        @(negedge clk); in_enable = 0;
        @(negedge clk); in_enable = 1;
        w0 = wr_cnt;
        trg_set(1);
        req_pulse(12'h701, 6);
        chk(wr_cnt == w0, "R8", wr_cnt - w0, 0);

        // R8 disable stops a running capture
        mode_trg_en = 0; restart(); w0 = wr_cnt;
        req_pulse(12'h702, 6);
        chk(wr_cnt == w0 + 1, "R8", wr_cnt - w0, 1);
        @(negedge clk); in_enable = 0;
        @(negedge clk); in_enable = 1;
        req_pulse(12'h703, 6);
        chk(wr_cnt == w0 + 1, "R8", wr_cnt - w0, 1);

        // R10 acknowledge width across the run
        chk(ack_wide == 0, "R10", ack_wide, 0);

        done = 1;
        finish_run();
    end
endmodule